// File: doc/BRIEF.md
# Forwarded-Clock Serial Link Endpoint

This block is one end of a single-lane, source-synchronous serial link. On the transmit side it accepts 32-bit words from an AXI4-Stream slave port clocked by the core clock. It registers each word once in the core domain and passes it to the I/O clock domain through a toggle handshake. There it shifts the word out one bit per I/O clock, together with a forwarded clock. A transmit enable, held by configuration logic outside the block, gates both the forwarded clock and the serial data.

On the receive side the block samples the incoming serial line on the incoming forwarded clock and writes each bit into a small bit-wide FIFO in that clock's domain. The FIFO absorbs phase offset and jitter between the received clock and the I/O clock. Its Gray-coded pointers cross the two domains through two-flop synchronizers. In the I/O domain a shift register rebuilds the words, and a single output register presents them on an AXI4-Stream master port. The core and I/O clocks are taken to be related, so the receive output sits directly in the I/O domain with only one register in front of it.

Top module: `ser_link`

## Requirements
- R1: While rst_ni is low, m_axis_tvalid_o, ser_tx_data_o and ser_tx_clk_o are low and s_axis_tready_o is high.
- R2: s_axis_tready_o is high only when the core-side holding register is empty. A word is accepted on a core clock edge where valid and ready are both high. Ready then stays low until the I/O domain has taken the word.
- R3: A transmitted frame is one start bit of value 1 followed by the 32 data bits, most significant bit first. The block sends one bit per I/O clock and drives the line low between frames. Data changes on the falling edge of ser_tx_clk_o, so the far end samples it on the rising edge.
- R4: While the transmit enable is low, ser_tx_clk_o and ser_tx_data_o stay low and no frame starts. A waiting word stays in the holding register. A change of the enable takes effect only between frames.
- R5: Every accepted word is transmitted exactly once, unchanged, in the order of acceptance.
- R6: ser_rx_data_i is sampled on each rising edge of ser_rx_clk_i into a bit FIFO of FIFO_DEPTH entries. The FIFO's Gray-coded pointers cross into the other domain through two-flop synchronizers.
- R7: The receiver uses the frame format of R3. It ignores low bits while hunting for a start bit. Each rebuilt word is shown on m_axis_tdata_o with m_axis_tvalid_o high, and it is held stable until m_axis_tready_i is high at a clock edge.
- R8: Words received on a clock with a fixed phase offset and bounded, non-accumulating jitter relative to clk_io_i arrive intact and in order.
- R9: If a word completes while the output register still holds a word that has not been accepted, the new word is discarded and the held word is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_core_i | input | 1 | Core clock for the stream input |
| clk_io_i | input | 1 | I/O clock for serializer, deserializer and stream output |
| rst_ni | input | 1 | Asynchronous active-low reset, all domains |
| tx_en_i | input | 1 | Transmit enable (core domain level from configuration) |
| s_axis_tdata_i | input | DATA_W | Transmit word |
| s_axis_tvalid_i | input | 1 | Transmit word valid |
| s_axis_tready_o | output | 1 | Holding register free |
| ser_tx_clk_o | output | 1 | Gated forwarded clock |
| ser_tx_data_o | output | 1 | Gated serial data |
| ser_rx_clk_i | input | 1 | Incoming forwarded clock |
| ser_rx_data_i | input | 1 | Incoming serial data |
| m_axis_tdata_o | output | DATA_W | Received word |
| m_axis_tvalid_o | output | 1 | Received word valid |
| m_axis_tready_i | input | 1 | Sink ready |

## Verification
The assertions assume that the received clock's average rate equals the I/O clock's. Under that condition the bit FIFO never fills, and the assertion watching the write side checks exactly this. The stimulus keeps within it by placing every received clock edge on an ideal grid with a fixed offset and adding at most 400 ps of jitter per edge that does not build up over time. The output-hold assertion places no demand on the sink. The sink's ready is driven away from clock edges, either held low for long stretches or pulsed one cycle in four, so that both the hold and the discard paths are exercised.

// File: rtl/ser_link_pkg.sv
`timescale 1ps/1ps
package ser_link_pkg;
  localparam logic FRAME_START = 1'b1;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_BODY = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ser_link_sync.sv
`timescale 1ps/1ps
module ser_link_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/ser_link_tx.sv
`timescale 1ps/1ps
module ser_link_tx
  import ser_link_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_core_i,
  input  logic              clk_io_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] s_tdata_i,
  input  logic              s_tvalid_i,
  output logic              s_tready_o,
  output logic              ser_clk_o,
  output logic              ser_data_o,
  output logic              gate_en_o,
  output logic              active_o
);
  localparam int CW = $clog2(DATA_W + 1);

  // core domain holding stage
  logic              busy_q, req_q, ack_core;
  logic [DATA_W-1:0] hold_q;
  // io domain
  logic              req_io, en_io, ack_q, active_q, gate_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W:0]   sh_q;
  logic              load;

  ser_link_sync #(.W(1)) u_ack_sync (
    .clk_i(clk_core_i), .rst_ni(rst_ni), .d_i(ack_q), .q_o(ack_core)
  );
  ser_link_sync #(.W(2)) u_req_sync (
    .clk_i(clk_io_i), .rst_ni(rst_ni), .d_i({req_q, tx_en_i}), .q_o({req_io, en_io})
  );

  always_ff @(posedge clk_core_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      hold_q <= '0;
    end else if (!busy_q) begin
      if (s_tvalid_i) begin
        hold_q <= s_tdata_i;
        busy_q <= 1'b1;
        req_q  <= ~req_q;
      end
    end else if (ack_core == req_q) begin
      busy_q <= 1'b0;
    end
  end

  assign s_tready_o = ~busy_q;

  // start only with the gate already open so the clock covers the whole frame
  assign load = !active_q && (req_io ^ ack_q) && en_io && gate_q;

  always_ff @(posedge clk_io_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q    <= 1'b0;
      active_q <= 1'b0;
      gate_q   <= 1'b0;
      cnt_q    <= '0;
      sh_q     <= '0;
    end else if (load) begin
      sh_q     <= {FRAME_START, hold_q};
      cnt_q    <= CW'(DATA_W);
      active_q <= 1'b1;
      ack_q    <= ~ack_q;
    end else if (!active_q) begin
      gate_q <= en_io;
    end else begin
      sh_q <= {sh_q[DATA_W-1:0], 1'b0};
      if (cnt_q == '0) active_q <= 1'b0;
      else             cnt_q    <= cnt_q - CW'(1);
    end
  end

  // gate changes on the io rising edge, while the inverted clock is falling
  assign ser_clk_o  = ~clk_io_i & gate_q;
  assign ser_data_o = gate_q & active_q & sh_q[DATA_W];
  assign gate_en_o  = gate_q;
  assign active_o   = active_q;
endmodule

// File: rtl/ser_link_rx_fifo.sv
`timescale 1ps/1ps
module ser_link_rx_fifo #(
  parameter int DEPTH = 8
) (
  input  logic wclk_i,
  input  logic rclk_i,
  input  logic rst_ni,
  input  logic wdata_i,
  output logic full_o,
  output logic rdata_o,
  output logic rvalid_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          mem_q [DEPTH];
  logic [PW-1:0] wbin_q, wgray_q, rbin_q, rgray_q;
  logic [PW-1:0] rgray_w, wgray_r;
  logic [PW-1:0] wbin_nxt, rbin_nxt;

  ser_link_sync #(.W(PW)) u_rptr_sync (
    .clk_i(wclk_i), .rst_ni(rst_ni), .d_i(rgray_q), .q_o(rgray_w)
  );
  ser_link_sync #(.W(PW)) u_wptr_sync (
    .clk_i(rclk_i), .rst_ni(rst_ni), .d_i(wgray_q), .q_o(wgray_r)
  );

  assign full_o   = (wgray_q == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
  assign rvalid_o = (rgray_q != wgray_r);
  assign wbin_nxt = wbin_q + PW'(1);
  assign rbin_nxt = rbin_q + PW'(1);

  always_ff @(posedge wclk_i) begin
    if (!full_o) mem_q[wbin_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (!full_o) begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  // reader pops every bit it sees; the deserializer never stalls
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (rvalid_o) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign rdata_o = mem_q[rbin_q[AW-1:0]];
endmodule

// File: rtl/ser_link_rx_deser.sv
`timescale 1ps/1ps
module ser_link_rx_deser
  import ser_link_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i
);
  localparam int CW = $clog2(DATA_W + 1);

  rx_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] sh_q, word_nxt;
  logic              word_done;

  assign word_nxt  = {sh_q[DATA_W-2:0], bit_i};
  assign word_done = (state_q == RX_BODY) && bit_valid_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_HUNT;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (bit_valid_i) begin
      if (state_q == RX_HUNT) begin
        if (bit_i == FRAME_START) begin
          state_q <= RX_BODY;
          cnt_q   <= CW'(DATA_W - 1);
        end
      end else begin
        sh_q <= word_nxt;
        if (cnt_q == '0) state_q <= RX_HUNT;
        else             cnt_q   <= cnt_q - CW'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_tvalid_o <= 1'b0;
      m_tdata_o  <= '0;
    end else if (word_done && (!m_tvalid_o || m_tready_i)) begin
      m_tvalid_o <= 1'b1;
      m_tdata_o  <= word_nxt;
    end else if (m_tvalid_o && m_tready_i) begin
      m_tvalid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_link.sv
`timescale 1ps/1ps
module ser_link #(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_core_i,
  input  logic              clk_io_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic [DATA_W-1:0] s_axis_tdata_i,
  input  logic              s_axis_tvalid_i,
  output logic              s_axis_tready_o,
  output logic              ser_tx_clk_o,
  output logic              ser_tx_data_o,
  input  logic              ser_rx_clk_i,
  input  logic              ser_rx_data_i,
  output logic [DATA_W-1:0] m_axis_tdata_o,
  output logic              m_axis_tvalid_o,
  input  logic              m_axis_tready_i
);
  logic tx_gate_en, tx_active;
  logic rx_fifo_full, rx_bit, rx_bit_valid;

  ser_link_tx #(.DATA_W(DATA_W)) u_tx (
    .clk_core_i (clk_core_i),
    .clk_io_i   (clk_io_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .s_tdata_i  (s_axis_tdata_i),
    .s_tvalid_i (s_axis_tvalid_i),
    .s_tready_o (s_axis_tready_o),
    .ser_clk_o  (ser_tx_clk_o),
    .ser_data_o (ser_tx_data_o),
    .gate_en_o  (tx_gate_en),
    .active_o   (tx_active)
  );

  ser_link_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .wclk_i   (ser_rx_clk_i),
    .rclk_i   (clk_io_i),
    .rst_ni   (rst_ni),
    .wdata_i  (ser_rx_data_i),
    .full_o   (rx_fifo_full),
    .rdata_o  (rx_bit),
    .rvalid_o (rx_bit_valid)
  );

  ser_link_rx_deser #(.DATA_W(DATA_W)) u_rx_deser (
    .clk_i       (clk_io_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (rx_bit_valid),
    .bit_i       (rx_bit),
    .m_tdata_o   (m_axis_tdata_o),
    .m_tvalid_o  (m_axis_tvalid_o),
    .m_tready_i  (m_axis_tready_i)
  );
endmodule

// File: rtl/ser_link_chk.sv
`timescale 1ps/1ps
module ser_link_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_core_i,
  input logic              clk_io_i,
  input logic              ser_rx_clk_i,
  input logic              rst_ni,
  input logic              s_axis_tvalid_i,
  input logic              s_axis_tready_o,
  input logic              ser_tx_data_o,
  input logic              m_axis_tvalid_o,
  input logic              m_axis_tready_i,
  input logic [DATA_W-1:0] m_axis_tdata_o,
  input logic              tx_gate_en,
  input logic              tx_active,
  input logic              rx_fifo_full
);
  p_accept_closes_r2: assert property (@(posedge clk_core_i) disable iff (!rst_ni)
    s_axis_tvalid_i && s_axis_tready_o |=> !s_axis_tready_o);

  p_start_bit_r3: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    $rose(tx_active) |-> ser_tx_data_o);

  p_gate_between_frames_r4: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    !$stable(tx_gate_en) |-> !$past(tx_active));

  p_no_overflow_r6: assert property (@(posedge ser_rx_clk_i) disable iff (!rst_ni)
    !rx_fifo_full);

  p_out_hold_r7: assert property (@(posedge clk_io_i) disable iff (!rst_ni)
    m_axis_tvalid_o && !m_axis_tready_i |=> m_axis_tvalid_o && $stable(m_axis_tdata_o));
endmodule

bind ser_link ser_link_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_core_i      (clk_core_i),
  .clk_io_i        (clk_io_i),
  .ser_rx_clk_i    (ser_rx_clk_i),
  .rst_ni          (rst_ni),
  .s_axis_tvalid_i (s_axis_tvalid_i),
  .s_axis_tready_o (s_axis_tready_o),
  .ser_tx_data_o   (ser_tx_data_o),
  .m_axis_tvalid_o (m_axis_tvalid_o),
  .m_axis_tready_i (m_axis_tready_i),
  .m_axis_tdata_o  (m_axis_tdata_o),
  .tx_gate_en      (tx_gate_en),
  .tx_active       (tx_active),
  .rx_fifo_full    (rx_fifo_full)
);

// File: tb/ser_link_tb_top.sv
`timescale 1ps/1ps
module ser_link_tb_top;
  localparam int W      = 32;
  localparam int HALF   = 2500;   // 200 MHz
  localparam int RX_OFF = 1700;

  logic          clk_core = 1'b0, clk_io = 1'b0, rx_clk = 1'b0;
  logic          rst_n = 1'b0, tx_en = 1'b0;
  logic [W-1:0]  s_data = '0;
  logic          s_valid = 1'b0, s_ready;
  logic          tx_clk, tx_data;
  logic          rx_data = 1'b0;
  logic [W-1:0]  m_data;
  logic          m_valid, m_ready = 1'b1;

  int n_chk = 0, n_err = 0, tx_edges = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_tx[$];
  logic [W-1:0] exp_rx[$];
  bit           rx_bits[$];

  ser_link #(.DATA_W(W), .FIFO_DEPTH(8)) dut_i (
    .clk_core_i(clk_core), .clk_io_i(clk_io), .rst_ni(rst_n), .tx_en_i(tx_en),
    .s_axis_tdata_i(s_data), .s_axis_tvalid_i(s_valid), .s_axis_tready_o(s_ready),
    .ser_tx_clk_o(tx_clk), .ser_tx_data_o(tx_data),
    .ser_rx_clk_i(rx_clk), .ser_rx_data_i(rx_data),
    .m_axis_tdata_o(m_data), .m_axis_tvalid_o(m_valid), .m_axis_tready_i(m_ready)
  );

  always #HALF clk_core = ~clk_core;
  initial begin
    #1000;
    forever #HALF clk_io = ~clk_io;
  end

  // received clock: ideal grid plus offset plus bounded jitter that does not accumulate
  initial begin
    longint k = 0;
    forever begin
      longint tgt;
      int j;
      j   = int'($urandom_range(800)) - 400;
      tgt = RX_OFF + k * HALF + j;
      if (tgt > $time) #(tgt - $time);
      else #1;
      rx_clk = ~rx_clk;
      k++;
    end
  end

  always @(negedge rx_clk) rx_data <= (rx_bits.size() > 0) ? rx_bits.pop_front() : 1'b0;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp, input string what);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_frame(input logic [W-1:0] w, input bit expect_it);
    rx_bits.push_back(1'b1);
    for (int i = W - 1; i >= 0; i--) rx_bits.push_back(w[i]);
    rx_bits.push_back(1'b0);
    rx_bits.push_back(1'b0);
    if (expect_it) exp_rx.push_back(w);
  endtask

  task automatic tx_send(input logic [W-1:0] w);
    @(negedge clk_core);
    while (!s_ready) @(negedge clk_core);
    s_valid = 1'b1;
    s_data  = w;
    exp_tx.push_back(w);
    @(negedge clk_core);
    s_valid = 1'b0;
  endtask

  task automatic set_ready(input logic r);
    @(posedge clk_io);
    #100;
    m_ready = r;
  endtask

  // TX model: idle low, start bit, MSB-first body, sampled on forwarded rising edge
  int           tx_st = 0, tx_cnt = 0;
  logic [W-1:0] tx_word = '0;
  always @(posedge tx_clk) begin
    tx_edges++;
    if (tx_st == 0) begin
      if (tx_data) begin tx_st = 1; tx_cnt = 0; end
    end else begin
      tx_word = {tx_word[W-2:0], tx_data};
      tx_cnt++;
      if (tx_cnt == W) begin
        tx_st = 0;
        if (exp_tx.size() == 0) check(1'b0, "R5", tx_word, '0, "unexpected tx frame");
        else begin
          logic [W-1:0] e;
          e = exp_tx.pop_front();
          check(tx_word == e, "R3", tx_word, e, "tx frame content/order (R5)");
        end
      end
    end
  end

  // RX model compared every io clock
  always @(negedge clk_io) begin
    if (rst_n && m_valid && m_ready) begin
      if (exp_rx.size() == 0) check(1'b0, "R9", m_data, '0, "word not expected");
      else begin
        logic [W-1:0] e;
        e = exp_rx.pop_front();
        check(m_data == e, "R8", m_data, e, "rx word content/order (R6 R7)");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk_io);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R5 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int e0;
    #12000;
    check(m_valid == 1'b0, "R1", {31'b0, m_valid}, '0, "tvalid in reset");
    check(tx_data == 1'b0, "R1", {31'b0, tx_data}, '0, "tx data in reset");
    check(tx_clk == 1'b0, "R1", {31'b0, tx_clk}, '0, "tx clock in reset");
    check(s_ready == 1'b1, "R1", {31'b0, s_ready}, 32'd1, "tready in reset");
    @(negedge clk_core);
    rst_n = 1'b1;
    repeat (5) @(negedge clk_core);

    // disabled transmitter holds the word
    tx_send(32'hA5C3_0F81);
    repeat (3) @(negedge clk_core);
    check(s_ready == 1'b0, "R2", {31'b0, s_ready}, '0, "tready after accept");
    e0 = tx_edges;
    repeat (100) @(negedge clk_io);
    check(tx_edges == e0, "R4", tx_edges, e0, "forwarded clock edges while disabled");
    check(tx_data == 1'b0, "R4", {31'b0, tx_data}, '0, "tx data while disabled");
    check(s_ready == 1'b0, "R4", {31'b0, s_ready}, '0, "word held while disabled");

    @(negedge clk_core);
    tx_en = 1'b1;
    fork
      begin
        tx_send(32'h0000_0001);
        tx_send(32'h8000_0000);
        tx_send(32'hFFFF_FFFF);
        tx_send(32'h1234_5678);
        tx_send(32'hDEAD_BEEF);
      end
      begin
        push_frame(32'h0000_0000, 1'b1);
        push_frame(32'hFFFF_FFFF, 1'b1);
        push_frame(32'h8000_0001, 1'b1);
        push_frame(32'h5555_AAAA, 1'b1);
        for (int i = 0; i < 4; i++) push_frame($urandom, 1'b1);
      end
    join
    repeat (2000) @(negedge clk_io);
    check(exp_tx.size() == 0, "R5", exp_tx.size(), '0, "tx words outstanding");
    check(exp_rx.size() == 0, "R8", exp_rx.size(), '0, "rx words outstanding");
    check(s_ready == 1'b1, "R2", {31'b0, s_ready}, 32'd1, "tready after drain");

    // output held, second word discarded
    set_ready(1'b0);
    push_frame(32'hC0DE_0001, 1'b1);
    push_frame(32'hC0DE_0002, 1'b0);
    repeat (300) @(negedge clk_io);
    check(m_valid == 1'b1, "R9", {31'b0, m_valid}, 32'd1, "held word valid");
    check(m_data == 32'hC0DE_0001, "R7", m_data, 32'hC0DE_0001, "held word stable");
    set_ready(1'b1);
    repeat (200) @(negedge clk_io);
    check(exp_rx.size() == 0, "R9", exp_rx.size(), '0, "held word delivered");
    check(m_valid == 1'b0, "R9", {31'b0, m_valid}, '0, "discarded word absent");

    // sink ready one cycle in four
    fork
      for (int i = 0; i < 4; i++) push_frame(32'h0F0F_0000 + i, 1'b1);
      for (int i = 0; i < 600; i++) set_ready((i % 4) == 3);
    join
    set_ready(1'b1);
    repeat (200) @(negedge clk_io);
    check(exp_rx.size() == 0, "R7", exp_rx.size(), '0, "throttled words delivered");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule